// File: doc/BRIEF.md
# Two-Rank Byte-Loadable DAC Code Register

This block is the digital front end of a 16-bit digital-to-analog converter. Its first rank holds an upper and a lower byte, each captured on its own enable, so an 8-bit host can assemble a full word over two writes while a 16-bit host writes both halves at once. A second rank, the converter register, takes the whole first-rank word and drives the code into the converter, so the analog output changes only when the host asks for it.

Every control is active low and level sensitive. A chip select gates all ranks. The transparent behaviour of a latch is reproduced on a system clock: while its enable condition holds, a stage takes its input on every rising clock edge. With every control low, bus data passes through both ranks and reaches the output two clocks later. Several instances can be loaded at different times and then switched together by one shared load signal.

Top module: `dac_code_reg`

## Requirements
- R1: A synchronous active-low reset clears both first-rank bytes and the converter register, so the code reads 0x0000 after reset and a load alone then leaves it at 0x0000.
- R2: While chip select (`cs_n`) is high, no rank changes, whatever the other three controls do.
- R3: With chip select low and the upper enable, lower enable and load controls all high, no rank changes.
- R4: With chip select low and `hi_en_n` low, the upper first-rank byte takes bus bits [15:8] on each clock; the lower byte is not touched.
- R5: With chip select low and `lo_en_n` low, the lower first-rank byte takes bus bits [7:0] on each clock; the upper byte is not touched.
- R6: With chip select low and `load_n` low, the converter register takes the first-rank word on each clock.
- R7: With all four controls low, a bus word appears on `dac_code` at the second rising edge after it is applied; after the first edge the output still shows the previous first-rank word.
- R8: While `load_n` is high, `dac_code` holds its value even as the first-rank bytes change.
- R9: With `load_n` driven low together with the second byte enable, the output takes the full word made of the earlier byte and the newly captured byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all ranks |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 16 | Data bus; an 8-bit host drives its byte on both halves |
| cs_n | input | 1 | Chip select, active low, gates every rank |
| hi_en_n | input | 1 | Upper byte enable, active low |
| lo_en_n | input | 1 | Lower byte enable, active low |
| load_n | input | 1 | Converter register load, active low |
| dac_code | output | 16 | Code driven to the converter |

## Verification
A wrong first-rank byte stays hidden until a load moves it to the output, so each byte write is followed later by a load and the resulting word is compared, which exposes a byte taken on the wrong lane or a lane overwritten by the other enable. A converter register that loads when it should hold shows up as soon as the first rank differs from the output, within one clock. The flow-through path is checked after one and after two edges so that an extra or missing stage of latency is seen directly.

// File: rtl/dac_code_reg_pkg.sv
// Shared definitions for the two-rank DAC code register.
// Assumes two byte lanes: lane 0 is the lower byte, lane 1 the upper byte.
package dac_code_reg_pkg;
    localparam int LANES = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    // Decoded per-cycle load strobes, active high
    typedef struct packed {
        logic [LANES-1:0] lane_ld;
        logic             conv_ld;
    } ld_strobes_t;
endpackage

// File: rtl/dac_ctl_decode.sv
// Turns the four active-low level controls into active-high load strobes.
// Assumes the controls are already synchronous to clk.
module dac_ctl_decode
    import dac_code_reg_pkg::*;
(
    input  logic        cs_n,
    input  logic        hi_en_n,
    input  logic        lo_en_n,
    input  logic        load_n,
    output ld_strobes_t strobes
);
    // Chip select qualifies every strobe
    always_comb begin
        strobes.lane_ld          = '0;
        strobes.lane_ld[LANE_HI] = !cs_n && !hi_en_n;
        strobes.lane_ld[LANE_LO] = !cs_n && !lo_en_n;
        strobes.conv_ld          = !cs_n && !load_n;
    end
endmodule

// File: rtl/dac_byte_lane.sv
// One first-rank byte: follows its bus slice on every clock while enabled.
// Assumes synchronous active-low reset to zero.
module dac_byte_lane #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [BYTE_W-1:0] d,
    output logic [BYTE_W-1:0] q
);
    // Hold or follow the bus slice
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R4 R5
    lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));
    // R4 R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/dac_conv_reg.sv
// Second rank: the converter register, follows the first-rank word while loaded.
// Assumes synchronous active-low reset to zero.
module dac_conv_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Hold or take the first-rank word
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R8
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/dac_code_reg.sv
// Two-rank byte-loadable DAC code register, top level.
// Assumes 16-bit bus split into two bytes; level transparency emulated on clk,
// so the full flow-through path takes two clock edges.
module dac_code_reg
    import dac_code_reg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*BYTE_W-1:0] bus_data,
    input  logic                    cs_n,
    input  logic                    hi_en_n,
    input  logic                    lo_en_n,
    input  logic                    load_n,
    output logic [LANES*BYTE_W-1:0] dac_code
);
    localparam int WORD_W = LANES * BYTE_W;

    ld_strobes_t       strobes;
    logic [WORD_W-1:0] rank1_word;

    dac_ctl_decode u_decode (
        .cs_n    (cs_n),
        .hi_en_n (hi_en_n),
        .lo_en_n (lo_en_n),
        .load_n  (load_n),
        .strobes (strobes)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dac_byte_lane #(.BYTE_W(BYTE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (strobes.lane_ld[g]),
            .d     (bus_data[g*BYTE_W +: BYTE_W]),
            .q     (rank1_word[g*BYTE_W +: BYTE_W])
        );
    end

    dac_conv_reg #(.WORD_W(WORD_W)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (strobes.conv_ld),
        .d     (rank1_word),
        .q     (dac_code)
    );

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(dac_code) && $stable(rank1_word)));
    // R3
    no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && hi_en_n && lo_en_n && load_n) |=> $stable(rank1_word));
    // R6
    conv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !load_n) |=> (dac_code == $past(rank1_word)));
endmodule

// File: tb/dac_code_reg_bench.sv
module dac_code_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        cs_n = 1'b1, hi_en_n = 1'b1, lo_en_n = 1'b1, load_n = 1'b1;
    logic [15:0] dac_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dac_code_reg u_dac_code_reg (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .cs_n(cs_n),
        .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .load_n(load_n), .dac_code(dac_code)
    );

    typedef struct packed {
        logic [3:0]  ctl;   // cs_n, hi_en_n, lo_en_n, load_n
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{4'b1000, 16'h1234, 16'h0000, 8'd2},  // R2 chip select high blocks all
        '{4'b0111, 16'h5678, 16'h0000, 8'd3},  // R3 no-op
        '{4'b0011, 16'hAB11, 16'h0000, 8'd4},  // R4 upper byte AB, output held (R8)
        '{4'b0101, 16'h22CD, 16'h0000, 8'd5},  // R5 lower byte CD
        '{4'b0110, 16'hFFFF, 16'hABCD, 8'd6},  // R6 load word
        '{4'b0000, 16'h8000, 16'h8000, 8'd7},  // R7 flow-through
        '{4'b1000, 16'h0FFF, 16'h8000, 8'd2},  // R2
        '{4'b0100, 16'h0012, 16'h8012, 8'd9},  // R9 second byte low, with load
        '{4'b0010, 16'h7F00, 16'h7F12, 8'd9},  // R9 second byte high, with load
        '{4'b0001, 16'h0001, 16'h7F12, 8'd8},  // R8 first rank changes, output held
        '{4'b0110, 16'h5555, 16'h0001, 8'd6},  // R6
        '{4'b0000, 16'hFFFF, 16'hFFFF, 8'd7},  // R7
        '{4'b0000, 16'h0000, 16'h0000, 8'd7}   // R7
    };

    task automatic check(input string req, input logic [15:0] exp);
        total++;
        if (dac_code !== exp) begin
            bad++;
            $display("FAIL %s: dac_code=%h expected=%h", req, dac_code, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [15:0] d);
        {cs_n, hi_en_n, lo_en_n, load_n} = ctl;
        bus_data = d;
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 16'h0000);          // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].ctl, TBL[i].data);
            repeat (2) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", TBL[i].req), TBL[i].exp);
        end
        // R7 latency: first rank currently 0000
        drive(4'b0000, 16'h1357);
        @(posedge clk); @(negedge clk);
        check("R7", 16'h0000);
        @(posedge clk); @(negedge clk);
        check("R7", 16'h1357);
        // R1 reset mid-run clears both ranks
        drive(4'b1111, 16'hFFFF);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", 16'h0000);
        rst_n = 1'b1;
        drive(4'b0110, 16'hFFFF);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", 16'h0000);           // R1 first rank was cleared too
        // R4 then R5 byte independence via a later load
        drive(4'b0011, 16'hA5FF);
        @(posedge clk); @(negedge clk);
        drive(4'b0101, 16'hFF3C);
        @(posedge clk); @(negedge clk);
        drive(4'b0110, 16'h0000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4", 16'hA53C);
        drive(4'b1111, 16'h0000);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule